// File: doc/BRIEF.md
# FIFO Threshold and Interrupt Flag Unit

This block holds a transmit FIFO, filled from the bus side and drained by the serial side, and a receive FIFO, filled by the serial side and drained by the bus side. It watches both FIFOs and turns what it sees into status. The transmit side raises a DMA request while its fill count is below a programmed level. The receive side raises one while its fill count is above a programmed level. The block also detects when the transmit FIFO empties and when the receive FIFO fills. It detects overrun and underrun attempts from either side of each FIFO.

Each event is caught in a sticky flag that software clears by writing one to the flag's bit. The flags are masked by an enable register and ORed into one interrupt line. The four level-type events also feed a second flag set with its own enables, and that set drives a wake-up output. Register access uses plain strobes: a write strobe with address and data, and a combinational read port.

Top module: `fifo_event_unit`

## Requirements
- R1: `dma_tx_req` is high exactly while the TX DMA enable (control register, address 0, bit 6) is 1 and the TX count is below the TX level (address 0, bits 5:0). Clearing the enable drops the request in the cycle after the write.
- R2: `dma_rx_req` is high exactly while the RX DMA enable (address 0, bit 14) is 1 and the RX count is above the RX level (address 0, bits 13:8).
- R3: The interrupt flag register (address 1) records the rising edge of each level condition, one cycle after the count change that causes it: bit 0 for TX count below its level, bit 1 for TX FIFO empty, bit 2 for RX count above its level, and bit 3 for RX FIFO full (count equal to DEPTH).
- R4: A bus push into a full TX FIFO is dropped and sets flag bit 12. A serial pop from an empty TX FIFO sets flag bit 13.
- R5: A serial push into a full RX FIFO is dropped and sets flag bit 14. A bus pop from an empty RX FIFO sets flag bit 15.
- R6: Writing 1 to a bit of address 1 or address 3 clears that flag, and writing 0 leaves it unchanged. A set in the same cycle as the clear wins, so the flag stays 1.
- R7: Writing 1 to address 0 bit 7 (TX) or bit 15 (RX) empties that FIFO. The same write clears that side's interrupt flags (TX: 0, 1, 12, 13; RX: 2, 3, 14, 15) and its wake flags. The clear itself does not cause an empty or threshold flag to set afterwards. A push in the same cycle is discarded.
- R8: `irq` is the OR of the interrupt flags ANDed with the enable register at address 2, which uses the same bit positions as address 1.
- R9: The wake flag register (address 3, bits 3:0) sets on the same four level edges as flags 0 to 3 of R3. It is cleared as in R6 and R7. `wake` is the OR of the wake flags ANDed with the wake enables at address 4, bits 3:0.
- R10: Both FIFOs return data in the order it was written, with the oldest entry shown on `ser_tx_data` and on `bus_rdata`. Address 5 reads the TX count in bits 7:0 and the RX count in bits 15:8, and neither count ever exceeds DEPTH.
- R11: After reset, all flags, enables and levels are 0, both FIFOs are empty, and `irq`, `wake`, `dma_tx_req` and `dma_rx_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Bus push into the TX FIFO |
| bus_wdata | input | DW | Data for the TX push |
| bus_rd | input | 1 | Bus pop from the RX FIFO |
| bus_rdata | output | DW | Oldest RX entry |
| ser_tx_pop | input | 1 | Serial pop from the TX FIFO |
| ser_tx_data | output | DW | Oldest TX entry |
| ser_rx_push | input | 1 | Serial push into the RX FIFO |
| ser_rx_data | input | DW | Data for the RX push |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on reg_addr |
| irq | output | 1 | Masked interrupt line |
| wake | output | 1 | Masked wake-up line |
| dma_tx_req | output | 1 | TX DMA request |
| dma_rx_req | output | 1 | RX DMA request |

## Verification
The bench builds the block with DEPTH = 8 and DW = 8, so eight pushes fill a FIFO. That puts the full flag and both overrun cases within a few cycles of a start. Because the 6-bit levels can be set to 8 or 9, the bench can also reach the edge cases: a level at DEPTH, where the RX threshold can never fire, and a level above DEPTH, where the TX threshold always holds. The bench also drives a clear and a set in the same cycle, and a FIFO clear while the FIFO holds data.

// File: rtl/fevu_pkg.sv
// Shared constants for the FIFO event unit: register addresses, field
// width of the threshold levels, and the mapping between the compact
// internal flag vector and its register bit positions.
package fevu_pkg;

    localparam int LVLW = 6;          // threshold level width
    localparam int RDW  = 16;         // register data width
    localparam int NFLG = 8;          // internal interrupt flags
    localparam int NWK  = 4;          // wake flags

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_IFLAG = 3'd1;
    localparam logic [2:0] A_IEN   = 3'd2;
    localparam logic [2:0] A_WFLAG = 3'd3;
    localparam logic [2:0] A_WEN   = 3'd4;
    localparam logic [2:0] A_LEVEL = 3'd5;

    // Internal order: [0] tx below, [1] tx empty, [2] rx above, [3] rx full,
    // [4] tx overrun, [5] tx underrun, [6] rx overrun, [7] rx underrun.
    function automatic logic [RDW-1:0] flags_to_reg(input logic [NFLG-1:0] f);
        return {f[7:4], 8'h00, f[3:0]};
    endfunction

    function automatic logic [NFLG-1:0] reg_to_flags(input logic [RDW-1:0] r);
        return {r[15:12], r[3:0]};
    endfunction

endpackage

// File: rtl/fevu_fifo.sv
// Circular FIFO with occupancy count. A push when full and a pop when empty
// are refused and reported as single-cycle overrun/underrun pulses. A
// synchronous clear empties it and overrides any push or pop that cycle.
// Assumes DEPTH >= 1; the read port shows the oldest entry (stale if empty).
module fevu_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          ovr,
    output logic          und
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign ovr     = push && full;
    assign und     = pop && empty;
    assign rdata   = mem[rd_ptr];

    // Storage write for accepted pushes.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy bookkeeping with reset and clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/fevu_flag_bank.sv
// Bank of sticky write-one-to-clear flags. Bits marked in EDGE_MASK set on
// the rising edge of their condition; the others set on every cycle their
// condition (a pulse) is high. A set beats a write-1 clear in the same
// cycle; a hard clear beats both and primes the edge history to 1 so the
// state left by the clear is not taken as a new edge.
module fevu_flag_bank #(
    parameter int           W         = 8,
    parameter logic [W-1:0] EDGE_MASK = '1,
    parameter logic [W-1:0] PREV_INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cond,
    input  logic [W-1:0] w1c,
    input  logic [W-1:0] hard_clr,
    output logic [W-1:0] flags
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic set_req;

        if (EDGE_MASK[i]) begin : g_edge
            logic prev;
            // History of the level condition for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n)           prev <= PREV_INIT[i];
                else if (hard_clr[i]) prev <= 1'b1;
                else                  prev <= cond[i];
            end
            assign set_req = cond[i] && !prev;
        end else begin : g_pulse
            assign set_req = cond[i];
        end

        // Sticky flag update with set-over-clear priority.
        always_ff @(posedge clk) begin
            if (!rst_n || hard_clr[i]) flags[i] <= 1'b0;
            else                       flags[i] <= set_req | (flags[i] & ~w1c[i]);
        end
    end

endmodule

// File: rtl/fifo_event_unit.sv
// FIFO event unit top: a TX FIFO (bus in, serial out) and an RX FIFO
// (serial in, bus out), level comparison for DMA requests, sticky event
// flags with masked interrupt and wake outputs, and a strobe register port.
// Assumes DEPTH <= 63 so counts fit the level fields and the count register.
module fifo_event_unit
    import fevu_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic [DW-1:0]  bus_wdata,
    input  logic           bus_rd,
    output logic [DW-1:0]  bus_rdata,
    input  logic           ser_tx_pop,
    output logic [DW-1:0]  ser_tx_data,
    input  logic           ser_rx_push,
    input  logic [DW-1:0]  ser_rx_data,
    input  logic           reg_wr,
    input  logic [2:0]     reg_addr,
    input  logic [RDW-1:0] reg_wdata,
    output logic [RDW-1:0] reg_rdata,
    output logic           irq,
    output logic           wake,
    output logic           dma_tx_req,
    output logic           dma_rx_req
);

    logic [LVLW-1:0] tx_lvl, rx_lvl;
    logic            tx_dma_en, rx_dma_en;
    logic [NFLG-1:0] ien, iflag, icond, ihard, iw1c;
    logic [NWK-1:0]  wen, wflag, whard, ww1c;
    logic [CW-1:0]   tx_cnt, rx_cnt;
    logic            tx_full, tx_empty, rx_full, rx_empty;
    logic            tx_ovr, tx_und, rx_ovr, rx_und;
    logic            tx_below, rx_above;
    logic            wr_ctrl, tx_clr, rx_clr;

    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign tx_clr  = wr_ctrl && reg_wdata[7];
    assign rx_clr  = wr_ctrl && reg_wdata[15];

    fevu_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(bus_wr), .wdata(bus_wdata),
        .pop(ser_tx_pop), .rdata(ser_tx_data),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty),
        .ovr(tx_ovr), .und(tx_und)
    );

    fevu_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(ser_rx_push), .wdata(ser_rx_data),
        .pop(bus_rd), .rdata(bus_rdata),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty),
        .ovr(rx_ovr), .und(rx_und)
    );

    // Control, interrupt-enable and wake-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_lvl    <= '0;
            rx_lvl    <= '0;
            tx_dma_en <= 1'b0;
            rx_dma_en <= 1'b0;
            ien       <= '0;
            wen       <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CTRL: begin
                    tx_lvl    <= reg_wdata[5:0];
                    tx_dma_en <= reg_wdata[6];
                    rx_lvl    <= reg_wdata[13:8];
                    rx_dma_en <= reg_wdata[14];
                end
                A_IEN:   ien <= reg_to_flags(reg_wdata);
                A_WEN:   wen <= reg_wdata[NWK-1:0];
                default: ;
            endcase
        end
    end

    assign tx_below = 8'(tx_cnt) < 8'(tx_lvl);
    assign rx_above = 8'(rx_cnt) > 8'(rx_lvl);

    assign icond = {rx_und, rx_ovr, tx_und, tx_ovr, rx_full, rx_above, tx_empty, tx_below};
    assign ihard = {rx_clr, rx_clr, tx_clr, tx_clr, rx_clr, rx_clr, tx_clr, tx_clr};
    assign whard = {rx_clr, rx_clr, tx_clr, tx_clr};
    assign iw1c  = (reg_wr && reg_addr == A_IFLAG) ? reg_to_flags(reg_wdata) : '0;
    assign ww1c  = (reg_wr && reg_addr == A_WFLAG) ? reg_wdata[NWK-1:0] : '0;

    fevu_flag_bank #(.W(NFLG), .EDGE_MASK(8'h0F), .PREV_INIT(8'h02)) u_iflags (
        .clk(clk), .rst_n(rst_n), .cond(icond),
        .w1c(iw1c), .hard_clr(ihard), .flags(iflag)
    );

    fevu_flag_bank #(.W(NWK), .EDGE_MASK(4'hF), .PREV_INIT(4'h2)) u_wflags (
        .clk(clk), .rst_n(rst_n), .cond(icond[NWK-1:0]),
        .w1c(ww1c), .hard_clr(whard), .flags(wflag)
    );

    assign irq        = |(iflag & ien);
    assign wake       = |(wflag & wen);
    assign dma_tx_req = tx_dma_en && tx_below;
    assign dma_rx_req = rx_dma_en && rx_above;

    // Combinational register read mux.
    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {1'b0, rx_dma_en, rx_lvl, 1'b0, tx_dma_en, tx_lvl};
            A_IFLAG: reg_rdata = flags_to_reg(iflag);
            A_IEN:   reg_rdata = flags_to_reg(ien);
            A_WFLAG: reg_rdata = {{(RDW-NWK){1'b0}}, wflag};
            A_WEN:   reg_rdata = {{(RDW-NWK){1'b0}}, wen};
            A_LEVEL: reg_rdata = {8'(rx_cnt), 8'(tx_cnt)};
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/fevu_checker.sv
// Property checker for fifo_event_unit, attached with bind below. It looks
// at FIFO counts, clear strobes and the internal flag vector.
module fevu_checker #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic          ser_rx_push,
    input logic          tx_clr,
    input logic          rx_clr,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic [7:0]    iflag,
    input logic [5:0]    tx_lvl,
    input logic          dma_tx_req
);

    assert_tx_ovr_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && tx_cnt == CW'(DEPTH) && !tx_clr) |=> iflag[4]);

    assert_rx_ovr_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_rx_push && rx_cnt == CW'(DEPTH) && !rx_clr) |=> iflag[6]);

    assert_tx_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clr |=> (tx_cnt == '0 && iflag[5:4] == 2'b00 && iflag[1:0] == 2'b00));

    assert_rx_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr |=> (rx_cnt == '0 && iflag[7:6] == 2'b00 && iflag[3:2] == 2'b00));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

    assert_dma_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dma_tx_req |-> (8'(tx_cnt) < 8'(tx_lvl)));

endmodule

bind fifo_event_unit fevu_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .ser_rx_push(ser_rx_push),
    .tx_clr(tx_clr), .rx_clr(rx_clr), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .iflag(iflag), .tx_lvl(tx_lvl), .dma_tx_req(dma_tx_req)
);

// File: tb/sim_fifo_event_unit.sv
// Bench for fifo_event_unit: behavioural reference model (queues, bit
// vectors) updated per clock and compared with the outputs every cycle.
module sim_fifo_event_unit;

    localparam int DW    = 8;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 0, bus_rd = 0, ser_tx_pop = 0, ser_rx_push = 0, reg_wr = 0;
    logic [7:0]  bus_wdata = 0, ser_rx_data = 0;
    logic [2:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0;
    logic [7:0]  bus_rdata, ser_tx_data;
    logic [15:0] reg_rdata;
    logic        irq, wake, dma_tx_req, dma_rx_req;

    int tests = 0, fails = 0;

    always #10 clk = ~clk;

    fifo_event_unit #(.DW(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .ser_tx_pop(ser_tx_pop),
        .ser_tx_data(ser_tx_data), .ser_rx_push(ser_rx_push),
        .ser_rx_data(ser_rx_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .wake(wake),
        .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
    );

    // Reference model state
    int          tx_q[$], rx_q[$];
    bit [7:0]    mf;        // internal flag order as in the requirements
    bit [3:0]    mw, m_wen, prv;
    bit [15:0]   m_ien;
    int          m_txl = 0, m_rxl = 0;
    bit          m_txen = 0, m_rxen = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit [15:0] mreg(input bit [2:0] a);
        case (a)
            3'd0: return {1'b0, m_rxen, 6'(m_rxl), 1'b0, m_txen, 6'(m_txl)};
            3'd1: return {mf[7:4], 8'h00, mf[3:0]};
            3'd2: return m_ien;
            3'd3: return {12'h0, mw};
            3'd4: return {12'h0, m_wen};
            3'd5: return {8'(rx_q.size()), 8'(tx_q.size())};
            default: return 16'h0;
        endcase
    endfunction

    // Advance the model by one clock using the inputs now applied.
    task automatic model_update();
        int ts = tx_q.size();
        int rs = rx_q.size();
        bit [7:0] c, w1c;
        bit [3:0] ww;
        bit tclr, rclr, hard, set;
        c[0] = ts < m_txl;  c[1] = ts == 0;
        c[2] = rs > m_rxl;  c[3] = rs == DEPTH;
        c[4] = bus_wr && ts == DEPTH;  c[5] = ser_tx_pop && ts == 0;
        c[6] = ser_rx_push && rs == DEPTH; c[7] = bus_rd && rs == 0;
        tclr = reg_wr && reg_addr == 0 && reg_wdata[7];
        rclr = reg_wr && reg_addr == 0 && reg_wdata[15];
        w1c = (reg_wr && reg_addr == 1) ? {reg_wdata[15:12], reg_wdata[3:0]} : 8'h0;
        ww  = (reg_wr && reg_addr == 3) ? reg_wdata[3:0] : 4'h0;
        for (int i = 0; i < 8; i++) begin
            hard = ((i & 2) == 0) ? tclr : rclr;
            set  = (i < 4) ? (c[i] && !prv[i % 4]) : c[i];
            mf[i] = hard ? 1'b0 : (set | (mf[i] & !w1c[i]));
            if (i < 4) begin
                mw[i]  = hard ? 1'b0 : (set | (mw[i] & !ww[i]));
                prv[i] = hard ? 1'b1 : c[i];
            end
        end
        if (reg_wr && reg_addr == 0) begin
            m_txl = int'(reg_wdata[5:0]);  m_txen = reg_wdata[6];
            m_rxl = int'(reg_wdata[13:8]); m_rxen = reg_wdata[14];
        end
        if (reg_wr && reg_addr == 2) m_ien = reg_wdata & 16'hF00F;
        if (reg_wr && reg_addr == 4) m_wen = reg_wdata[3:0];
        if (tclr) tx_q.delete();
        else begin
            if (ser_tx_pop && ts > 0) void'(tx_q.pop_front());
            if (bus_wr && ts < DEPTH) tx_q.push_back(int'(bus_wdata));
        end
        if (rclr) rx_q.delete();
        else begin
            if (bus_rd && rs > 0) void'(rx_q.pop_front());
            if (ser_rx_push && rs < DEPTH) rx_q.push_back(int'(ser_rx_data));
        end
    endtask

    task automatic compare_all();
        bit e_irq  = |({mf[7:4], 8'h00, mf[3:0]} & m_ien);
        bit e_wake = |(mw & m_wen);
        bit e_dtx  = m_txen && (tx_q.size() < m_txl);
        bit e_drx  = m_rxen && (rx_q.size() > m_rxl);
        check(irq == e_irq, "R8 irq", int'(irq), int'(e_irq));
        check(wake == e_wake, "R9 wake", int'(wake), int'(e_wake));
        check(dma_tx_req == e_dtx, "R1 dma_tx_req", int'(dma_tx_req), int'(e_dtx));
        check(dma_rx_req == e_drx, "R2 dma_rx_req", int'(dma_rx_req), int'(e_drx));
        if (tx_q.size() > 0)
            check(int'(ser_tx_data) == tx_q[0], "R10 ser_tx_data", int'(ser_tx_data), tx_q[0]);
        if (rx_q.size() > 0)
            check(int'(bus_rdata) == rx_q[0], "R10 bus_rdata", int'(bus_rdata), rx_q[0]);
    endtask

    task automatic tick();
        model_update();
        @(posedge clk);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; ser_tx_pop = 0; ser_rx_push = 0; reg_wr = 0;
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wreg(input bit [2:0] a, input bit [15:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d; tick();
    endtask

    task automatic rd(input bit [2:0] a, input string tag);
        reg_addr = a; #1;
        check(reg_rdata == mreg(a), tag, int'(reg_rdata), int'(mreg(a)));
    endtask

    task automatic bpush(input bit [7:0] d); bus_wr = 1; bus_wdata = d; tick(); endtask
    task automatic spush(input bit [7:0] d); ser_rx_push = 1; ser_rx_data = d; tick(); endtask
    task automatic spop(); ser_tx_pop = 1; tick(); endtask
    task automatic bpop(); bus_rd = 1; tick(); endtask

    initial begin
        #(100000 * 20);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        prv = 4'b0010; mf = 0; mw = 0; m_wen = 0; m_ien = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R11: reset state
        reg_addr = 3'd1; #1;
        check(reg_rdata == 16'h0, "R11 flags after reset", int'(reg_rdata), 0);
        check({irq, wake, dma_tx_req, dma_rx_req} == 4'b0, "R11 outputs after reset",
              int'({irq, wake, dma_tx_req, dma_rx_req}), 0);
        rd(3'd5, "R11 counts after reset");
        idle(2);

        // Enable everything; TX level 3 with DMA, RX level 2 with DMA
        wreg(3'd2, 16'hFFFF);
        wreg(3'd4, 16'h000F);
        wreg(3'd0, 16'h4243);
        idle(2);
        rd(3'd1, "R3 tx below flag");
        rd(3'd3, "R9 wake flags");

        // Fill TX FIFO and overrun it
        for (int i = 0; i < DEPTH; i++) bpush(8'h10 + 8'(i));
        reg_addr = 3'd5; #1;
        check(reg_rdata == 16'h0008, "R10 tx count full", int'(reg_rdata), 16'h0008);
        bpush(8'hEE);
        reg_addr = 3'd1; #1;
        check(reg_rdata[12] == 1'b1, "R4 tx overrun flag", int'(reg_rdata[12]), 1);
        rd(3'd5, "R4 dropped push");

        // Clear and set in the same cycle: set wins
        bus_wr = 1; bus_wdata = 8'hEF; reg_wr = 1; reg_addr = 3'd1; reg_wdata = 16'h1000; tick();
        rd(3'd1, "R6 set beats clear");
        wreg(3'd1, 16'h1000);
        rd(3'd1, "R6 write one clears");
        wreg(3'd1, 16'h0000);
        rd(3'd1, "R6 write zero keeps");

        // Drain TX serially, then underrun
        for (int i = 0; i < DEPTH; i++) spop();
        spop();
        idle(2);
        rd(3'd1, "R4 tx underrun and empty");
        wreg(3'd3, 16'h000F);
        rd(3'd3, "R6 wake clear");

        // RX fill past level, overrun, drain, underrun
        for (int i = 0; i < DEPTH; i++) spush(8'hA0 + 8'(i));
        spush(8'h55);
        idle(2);
        rd(3'd1, "R5 rx above, full, overrun");
        rd(3'd3, "R9 rx wake flags");
        for (int i = 0; i < DEPTH; i++) bpop();
        bpop();
        idle(1);
        rd(3'd1, "R5 rx underrun");

        // Mask interrupts off: irq must drop with flags still set
        wreg(3'd2, 16'h0000);
        wreg(3'd4, 16'h0000);
        idle(2);
        check(irq == 1'b0, "R8 masked irq", int'(irq), 0);

        // FIFO clear with data present (RX level 8: never above; TX level 9: always below)
        wreg(3'd2, 16'hF00F);
        wreg(3'd0, 16'h4849);
        for (int i = 0; i < 5; i++) bpush(8'h30 + 8'(i));
        for (int i = 0; i < 5; i++) spush(8'h60 + 8'(i));
        bus_wr = 1; bus_wdata = 8'h77;
        wreg(3'd0, 16'hC8C9);
        idle(2);
        rd(3'd5, "R7 both fifos emptied");
        rd(3'd1, "R7 flags cleared and not re-set");
        rd(3'd3, "R7 wake flags cleared");

        // DMA disable drops the requests
        wreg(3'd0, 16'h0809);
        idle(1);
        check(dma_tx_req == 1'b0, "R1 dma disabled", int'(dma_tx_req), 0);
        rd(3'd0, "R1 control readback");

        // Interleaved push/pop order
        wreg(3'd0, 16'h4203);
        for (int i = 0; i < 6; i++) begin
            bus_wr = 1; bus_wdata = 8'(i * 7);
            ser_tx_pop = (i % 2 == 1);
            ser_rx_push = 1; ser_rx_data = 8'(i * 3);
            bus_rd = (i % 3 == 2);
            tick();
        end
        idle(2);
        rd(3'd5, "R10 interleaved counts");
        rd(3'd1, "R3 interleaved flags");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule